// File: doc/BRIEF.md
# Weight-Stationary Int8 MAC Grid

This block is an N-by-N grid of multiply-accumulate cells. Each cell holds one signed 8-bit weight, loaded once and kept for any number of runs. Signed 8-bit activation vectors enter through a valid/ready stream. Inside the grid, activations move to the right and partial sums move down. The results leave as whole vectors of signed 32-bit column sums, one output vector per input vector.

Weights are written one column per beat. A run starts with a start pulse, which also captures the run length as "rows minus one" (1 to 256 rows). After the last result has been taken, a single-cycle done pulse marks the end of the run. Address generation, bias, quantization and bus access belong to the logic around this block.

The grid edge N is fixed at elaboration to 8, 16 or 32. Input rows are skewed by one stage per row on the way in, and column sums are realigned on the way out. When the result consumer holds off, the whole pipeline freezes.

Top module: `ws_mac_grid`

## Requirements
- R1: While reset is high, and in the cycle after it, `out_valid`, `done` and `in_ready` are 0.
- R2: While idle, each `wt_valid` beat writes the next weight column, starting at column 0 and going up to column N-1. Byte r of `wt_col` (bits 8r+7..8r) becomes the weight of row r. A start pulse is ignored until all N columns have been written, so `in_ready` stays 0.
- R3: Each output vector holds, in bits 32c+31..32c, the signed sum over r of x[r]*W[r][c]. Here x[r] is byte r of the accepted `in_data`. The sum is exact for every int8 operand, including -128.
- R4: `rows_m1` is sampled on an accepted start. Exactly rows_m1+1 input vectors are then accepted, with `in_ready` held at 0 afterwards even while `in_valid` stays high. The same number of output vectors leave, in acceptance order.
- R5: `done` is high for exactly one cycle: the cycle after the handshake of the last output vector of the run.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values and `in_ready` is 0.
- R7: Weights persist between runs. A new start without a reload uses the same weights.
- R8: `wt_valid` beats and start pulses that arrive during a run are ignored. The results of that run and of later runs are unchanged by them.
- R9: With `out_ready` held high, the first output of a run has `out_valid` high 2N+2 cycles after the cycle in which the first input was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_valid | input | 1 | Weight column beat |
| wt_col | input | N*8 | One column of weights, byte r for row r |
| start | input | 1 | Start a run (honoured when idle and loaded) |
| rows_m1 | input | 8 | Rows in the run minus one |
| in_valid | input | 1 | Activation vector valid |
| in_ready | output | 1 | Activation vector accepted when high with in_valid |
| in_data | input | N*8 | Activation vector, byte r for row r |
| out_valid | output | 1 | Result vector valid |
| out_ready | input | 1 | Consumer ready for result vector |
| out_data | output | N*32 | Result vector, word c for column c |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench loads weights in two halves, with a start in between, to show that a grid that starts on a partial load is caught by R2. It streams -128 operands against -128 weights. A sum that wraps, or a product extended without its sign, gives wrong column values there. Runs with bubbles on the input and periodic hold-off on the output would expose a de-skew that slips relative to the valid pipeline: vectors would mix across columns or show up twice. Runs of one row and of 256 rows test the length counters, where an off-by-one accepts one vector too many or too few, or moves the done pulse.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int unsigned WSG_ACT_W = 8;
  localparam int unsigned WSG_ACC_W = 32;
  localparam int unsigned WSG_ROWS_W = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wsg_state_e;

  function automatic bit wsg_edge_ok(input int unsigned n);
    return (n == 8) || (n == 16) || (n == 32);
  endfunction
endpackage

// File: rtl/wsg_delay.sv
module wsg_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg[i] <= '0;
      end else if (en) begin
        if (i == 0) stg[i] <= d;
        else        stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/wsg_pe.sv
module wsg_pe #(
  parameter int unsigned ACT_W = 8,
  parameter int unsigned ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    w_load,
  input  logic signed [ACT_W-1:0] w_in,
  input  logic signed [ACT_W-1:0] a_in,
  input  logic signed [ACC_W-1:0] p_in,
  output logic signed [ACT_W-1:0] a_out,
  output logic signed [ACC_W-1:0] p_out
);
  localparam int unsigned PROD_W = 2 * ACT_W;

  logic signed [ACT_W-1:0]  w_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;

  assign prod     = a_in * w_q;
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q   <= '0;
      a_out <= '0;
      p_out <= '0;
    end else begin
      if (w_load) w_q <= w_in;
      if (adv) begin
        a_out <= a_in;
        p_out <= p_in + prod_ext;
      end
    end
  end
endmodule

// File: rtl/wsg_ctrl.sv
module wsg_ctrl
  import wsg_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned ROWS_W = 8,
  localparam int unsigned COL_W = $clog2(N),
  localparam int unsigned CNT_W = ROWS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wt_valid,
  input  logic              start,
  input  logic [ROWS_W-1:0] rows_m1,
  input  logic              in_valid,
  input  logic              adv,
  input  logic              out_fire,
  output logic              wt_we,
  output logic [COL_W-1:0]  wt_idx,
  output logic              in_ready,
  output logic              in_fire,
  output logic              done
);
  wsg_state_e        state;
  logic [COL_W-1:0]  wcol;
  logic              loaded;
  logic [ROWS_W-1:0] m1_q;
  logic [CNT_W-1:0]  in_cnt;
  logic [CNT_W-1:0]  out_cnt;
  logic              idle;
  logic              start_ok;
  logic              last_fire;

  assign idle      = (state == ST_IDLE);
  assign wt_we     = idle && wt_valid;
  assign wt_idx    = wcol;
  assign start_ok  = idle && loaded && start && !wt_valid;
  assign in_ready  = (state == ST_RUN) && (in_cnt <= {1'b0, m1_q}) && adv;
  assign in_fire   = in_ready && in_valid;
  assign last_fire = (state == ST_RUN) && out_fire && (out_cnt == {1'b0, m1_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      wcol    <= '0;
      loaded  <= 1'b0;
      m1_q    <= '0;
      in_cnt  <= '0;
      out_cnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (wt_we) begin
        loaded <= (wcol == COL_W'(N-1));
        wcol   <= (wcol == COL_W'(N-1)) ? '0 : wcol + 1'b1;
      end
      if (start_ok) begin
        state   <= ST_RUN;
        m1_q    <= rows_m1;
        in_cnt  <= '0;
        out_cnt <= '0;
      end
      if (state == ST_RUN) begin
        if (in_fire)  in_cnt  <= in_cnt + 1'b1;
        if (out_fire) out_cnt <= out_cnt + 1'b1;
        if (last_fire) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ws_mac_grid.sv
module ws_mac_grid
  import wsg_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned ACT_W  = WSG_ACT_W,
  parameter int unsigned ACC_W  = WSG_ACC_W,
  parameter int unsigned ROWS_W = WSG_ROWS_W,
  localparam int unsigned COL_W = $clog2(N),
  localparam int unsigned LAT   = 2 * N + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wt_valid,
  input  logic [N*ACT_W-1:0]   wt_col,
  input  logic                 start,
  input  logic [ROWS_W-1:0]    rows_m1,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [N*ACT_W-1:0]   in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [N*ACC_W-1:0]   out_data,
  output logic                 done
);
  if (!wsg_edge_ok(N)) begin : g_bad_n
    $error("ws_mac_grid: N must be 8, 16 or 32");
  end

  logic             adv;
  logic             out_fire;
  logic             wt_we;
  logic [COL_W-1:0] wt_idx;
  logic             in_fire;
  logic             vld_tail;

  logic signed [ACT_W-1:0] skew_q [N];
  logic signed [ACT_W-1:0] a_src  [N][N];
  logic signed [ACT_W-1:0] a_h    [N][N];
  logic signed [ACC_W-1:0] p_src  [N][N];
  logic signed [ACC_W-1:0] p_v    [N][N];
  logic [ACC_W-1:0]        col_sum [N];
  logic [N*ACC_W-1:0]      sum_flat;

  assign adv      = !out_valid || out_ready;
  assign out_fire = out_valid && out_ready;

  wsg_ctrl #(.N(N), .ROWS_W(ROWS_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wt_valid (wt_valid),
    .start    (start),
    .rows_m1  (rows_m1),
    .in_valid (in_valid),
    .adv      (adv),
    .out_fire (out_fire),
    .wt_we    (wt_we),
    .wt_idx   (wt_idx),
    .in_ready (in_ready),
    .in_fire  (in_fire),
    .done     (done)
  );

  // Valid tag travels alongside the wavefront: skew, grid, de-skew
  wsg_delay #(.W(1), .DEPTH(LAT)) u_vld (
    .clk (clk),
    .rst (rst),
    .en  (adv),
    .d   (in_fire),
    .q   (vld_tail)
  );

  // Input skew: row r waits r+1 stages
  for (genvar r = 0; r < N; r++) begin : g_skew
    logic [ACT_W-1:0] sk_d;
    logic [ACT_W-1:0] sk_q;
    assign sk_d = in_fire ? in_data[r*ACT_W +: ACT_W] : '0;
    wsg_delay #(.W(ACT_W), .DEPTH(r + 1)) u_sk (
      .clk (clk),
      .rst (rst),
      .en  (adv),
      .d   (sk_d),
      .q   (sk_q)
    );
    assign skew_q[r] = sk_q;
  end

  // Cell grid: activations go right, partial sums go down
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      if (c == 0) begin : g_aedge
        assign a_src[r][c] = skew_q[r];
      end else begin : g_ain
        assign a_src[r][c] = a_h[r][c-1];
      end
      if (r == 0) begin : g_pedge
        assign p_src[r][c] = '0;
      end else begin : g_pin
        assign p_src[r][c] = p_v[r-1][c];
      end
      wsg_pe #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_pe (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .w_load (wt_we && (wt_idx == COL_W'(c))),
        .w_in   (wt_col[r*ACT_W +: ACT_W]),
        .a_in   (a_src[r][c]),
        .p_in   (p_src[r][c]),
        .a_out  (a_h[r][c]),
        .p_out  (p_v[r][c])
      );
    end
  end

  // De-skew: column c waits N-c stages
  for (genvar c = 0; c < N; c++) begin : g_dsk
    wsg_delay #(.W(ACC_W), .DEPTH(N - c)) u_dsk (
      .clk (clk),
      .rst (rst),
      .en  (adv),
      .d   (p_v[N-1][c]),
      .q   (col_sum[c])
    );
  end

  always_comb begin
    for (int c = 0; c < N; c++) begin
      sum_flat[c*ACC_W +: ACC_W] = col_sum[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= vld_tail;
      if (vld_tail) out_data <= sum_flat;
    end
  end
endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
  parameter int unsigned N     = 8,
  parameter int unsigned ACC_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [N*ACC_W-1:0] out_data,
  input logic               done
);
  logic [31:0] n_in;
  logic [31:0] n_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      if (in_valid && in_ready)   n_in  <= n_in + 1'b1;
      if (out_valid && out_ready) n_out <= n_out + 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !done && !in_ready));

  a_r6_hold_result: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_stall_input: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_drained: assert property (@(posedge clk) disable iff (rst)
    done |-> (!out_valid && (n_in == n_out)));

  a_r4_out_after_in: assert property (@(posedge clk) disable iff (rst)
    n_out <= n_in);
endmodule

bind ws_mac_grid wsg_checker #(.N(N), .ACC_W(ACC_W)) u_wsg_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done)
);

// File: tb/ws_mac_grid_bench.sv
module ws_mac_grid_bench;
  localparam int N  = 8;
  localparam int AW = 8;
  localparam int SW = 32;

  localparam logic [N*AW-1:0] TBL [6] = '{
    64'h8080_8080_8080_8080,
    64'h7f7f_7f7f_7f7f_7f7f,
    64'h0102_0304_0506_0708,
    64'hff01_fe02_fd03_fc04,
    64'h807f_00ff_0180_7f00,
    64'h0000_0000_0000_0000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wt_valid = 1'b0;
  logic [N*AW-1:0] wt_col = '0;
  logic start = 1'b0;
  logic [7:0] rows_m1 = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*AW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [N*SW-1:0] out_data;
  logic done;

  int nchk  = 0;
  int nfail = 0;
  int wts [N][N];

  always #10 clk = ~clk;

  ws_mac_grid #(.N(N)) u_ws_mac_grid (
    .clk(clk), .rst(rst), .wt_valid(wt_valid), .wt_col(wt_col),
    .start(start), .rows_m1(rows_m1), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [N*AW-1:0] gen_vec(input int i);
    logic [N*AW-1:0] v;
    for (int r = 0; r < N; r++) v[r*AW +: AW] = 8'((i * 7 + r * 13 + 5) % 256);
    return v;
  endfunction

  function automatic logic [N*AW-1:0] vec(input int i);
    return (i < 6) ? TBL[i] : gen_vec(i);
  endfunction

  function automatic logic [N*SW-1:0] ref_out(input logic [N*AW-1:0] x);
    logic [N*SW-1:0] res;
    for (int c = 0; c < N; c++) begin
      int s = 0;
      for (int r = 0; r < N; r++) s += int'($signed(x[r*AW +: AW])) * wts[r][c];
      res[c*SW +: SW] = 32'(s);
    end
    return res;
  endfunction

  task automatic load_cols(input int first, input int last);
    for (int c = first; c <= last; c++) begin
      @(negedge clk);
      wt_valid = 1'b1;
      for (int r = 0; r < N; r++) wt_col[r*AW +: AW] = 8'(wts[r][c]);
    end
    @(negedge clk);
    wt_valid = 1'b0;
  endtask

  task automatic do_run(input int m1, input bit bub, input bit bp, input bit inj);
    int m = m1 + 1;
    int acc = 0, got = 0, ndone = 0;
    int first_acc = -1, first_out = -1, last_hs = -1, done_cyc = -1;
    bit stall_prev = 0;
    logic [N*SW-1:0] held = '0;
    int limit = 4 * m + 200;
    @(negedge clk);
    start = 1'b1;
    rows_m1 = 8'(m1);
    for (int cyc = 0; cyc < limit; cyc++) begin
      @(negedge clk);
      start     = inj && (cyc == 4);
      wt_valid  = inj && (cyc == 3);
      wt_col    = '0;
      in_valid  = !(bub && (cyc % 4 == 1));
      in_data   = vec(acc);
      out_ready = !(bp && (cyc % 5 < 2));
      #1;
      if (stall_prev)
        chk(out_valid && out_data == held, "R6", "held result", out_data, held);
      stall_prev = 0;
      if (out_valid && !out_ready) begin
        chk(!in_ready, "R6", "in_ready during stall", in_ready, 0);
        stall_prev = 1;
        held = out_data;
      end
      if (in_valid && in_ready) begin
        if (first_acc < 0) first_acc = cyc;
        acc++;
      end
      if (out_valid && first_out < 0) first_out = cyc;
      if (out_valid && out_ready) begin
        chk(out_data == ref_out(vec(got)), "R3", "column sums", out_data, ref_out(vec(got)));
        got++;
        if (got == m) last_hs = cyc;
      end
      if (done) begin
        ndone++;
        done_cyc = cyc;
      end
      if (done_cyc >= 0 && cyc >= done_cyc + 2) break;
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    start     = 1'b0;
    wt_valid  = 1'b0;
    chk(acc == m, "R4", "accepted count", acc, m);
    chk(got == m, "R4", "output count", got, m);
    chk(done_cyc == last_hs + 1 && last_hs >= 0, "R5", "done cycle", done_cyc, last_hs + 1);
    chk(ndone == 1, "R5", "done pulses", ndone, 1);
    if (!bub && !bp)
      chk(first_out == first_acc + 2 * N + 2, "R9", "first result latency",
          first_out - first_acc, 2 * N + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R4 watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    bit seen;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wts[r][c] = ((r * 37 + c * 11 + 3) % 256) - 128;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!out_valid && !done && !in_ready, "R1", "outputs in reset",
        {out_valid, done, in_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !done && !in_ready, "R1", "outputs after reset",
        {out_valid, done, in_ready}, 0);

    // R2: start with no weights is ignored
    @(negedge clk);
    start = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    repeat (5) begin @(negedge clk); #1; if (in_ready) seen = 1; end
    chk(!seen, "R2", "ready without weights", seen, 0);

    // R2: start after half a load is ignored
    load_cols(0, N/2 - 1);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    repeat (5) begin @(negedge clk); #1; if (in_ready) seen = 1; end
    chk(!seen, "R2", "ready after partial load", seen, 0);
    in_valid = 1'b0;
    load_cols(N/2, N - 1);

    do_run(5, 0, 0, 0);     // R3 R4 R5 R9 table vectors
    do_run(0, 0, 0, 0);     // single row
    do_run(19, 1, 1, 0);    // bubbles and hold-off
    do_run(9, 0, 0, 1);     // R8 ignored beats, R7 persisted weights
    do_run(255, 0, 1, 0);   // 256 rows

    // R3: extreme operands
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wts[r][c] = -128;
    load_cols(0, N - 1);
    do_run(1, 0, 0, 0);
    chk(ref_out(TBL[0])[31:0] == 32'd131072, "R3", "bench model -128 sum",
        ref_out(TBL[0])[31:0], 131072);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule